// File: doc/BRIEF.md
# Gradient Direction Angle Unit

This block turns three oscillator frequency readings from one triangular sensor cell into the direction of a single heat source. The readings come from sensors at corners A, B and C of the triangle, in kHz. From them the block forms the tangent of the bearing angle toward the hot spot as a signed integer worth one thousandth per count. It also gives the angle itself in milliradians. A later stage that combines two such cells to place the source and estimate its temperature uses both values.

All arithmetic is integer. The irrational factor in the formula is held as a fixed-point constant, so the quotient comes from one shared restoring divider. An iterative shift-and-add arctangent stage then turns the tangent into an angle. A request is taken with a one-cycle strobe while the block is idle. The result appears a fixed number of cycles later, with a one-cycle valid strobe, and stays on the outputs until the next result.

Top module: `gds_angle_unit`

## Requirements
- R1: With dB = fB − fA and dC = fC − fA, the tangent output equals 1000·(2·dB − dC)/(√3·dC), truncated toward zero, which is the same as 1000·(2·dB/(√3·dC) − 1/√3).
- R2: Readings (10500, 10600, 10700) give tangent 0, (101000, 108000, 112000) give 157, and (120000, 130000, 137000) give 101.
- R3: The angle output is within one count of round(1000·atan(tangent/1000)), in milliradians, for every tangent the block produces.
- R4: When fC equals fA, the error output is 1 and both the tangent and the angle are 0. Otherwise the error output is 0.
- R5: A tangent whose magnitude would exceed 2^(TAN_W−1)−1 is clamped to ±(2^(TAN_W−1)−1), keeping its sign. The most negative code is never produced.
- R6: out_valid is high for exactly one cycle, FREQ_W+47 clock cycles after the edge that accepts a request (71 at the defaults). Between results the tangent, angle and error outputs hold their values.
- R7: busy rises on the edge that accepts a request and falls on the edge that raises out_valid. A strobe on in_valid while busy is high is ignored: no extra result appears and the pending result is unchanged.
- R8: When 2·dB − dC and dC have opposite signs, the tangent and the angle are both negative.
- R9: After reset, busy, out_valid, err and both data outputs are 0.
- R10: A request may be accepted in the same cycle as out_valid, so results can follow one another every FREQ_W+47 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; sampled only while busy is low |
| fa_khz | input | FREQ_W | Frequency of corner A, unsigned kHz |
| fb_khz | input | FREQ_W | Frequency of corner B, unsigned kHz |
| fc_khz | input | FREQ_W | Frequency of corner C, unsigned kHz |
| busy | output | 1 | A request is in progress |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| tan_milli | output | TAN_W | Signed tangent, one count = 0.001 |
| angle_mrad | output | TAN_W | Signed angle in milliradians |
| err | output | 1 | Degenerate cell (fC equal to fA) for the current result |

## Verification
A corrupted remainder or a miscounted step in the divider shows up at once in the next tangent, as a wrong value against the real-number reference. A wrong step count also moves the valid strobe away from its fixed cycle. A faulty arctangent step table or rotation direction gives an angle outside the one-count band, or with the wrong sign, on the very same result. Sign and clamping faults show up on the negative and the oversized cases. A stuck busy flag shows up either as a second result after an ignored strobe or as a hang that the latency check catches within one request period.

// File: rtl/gds_pkg.sv
package gds_pkg;

    // round(1000/sqrt(3) * 2^16): shared scale for the whole tangent quotient
    localparam int     K_W          = 26;
    localparam longint INV_SQRT3_Q  = 64'd37837227;
    localparam int     RATIO_FRAC   = 16;

    // arctangent stage
    localparam int     CORDIC_ITER  = 16;
    localparam int     XY_FRAC      = 12;
    localparam int     Z_FRAC       = 8;

    // atan(2^-i) in milliradians with Z_FRAC fractional bits
    function automatic logic [23:0] atan_step_q8(input int idx);
        case (idx)
            0:  atan_step_q8 = 24'd201062;
            1:  atan_step_q8 = 24'd118694;
            2:  atan_step_q8 = 24'd62715;
            3:  atan_step_q8 = 24'd31835;
            4:  atan_step_q8 = 24'd15979;
            5:  atan_step_q8 = 24'd7997;
            6:  atan_step_q8 = 24'd4000;
            7:  atan_step_q8 = 24'd2000;
            8:  atan_step_q8 = 24'd1000;
            9:  atan_step_q8 = 24'd500;
            10: atan_step_q8 = 24'd250;
            11: atan_step_q8 = 24'd125;
            12: atan_step_q8 = 24'd62;
            13: atan_step_q8 = 24'd31;
            14: atan_step_q8 = 24'd16;
            default: atan_step_q8 = 24'd8;
        endcase
    endfunction

endpackage

// File: rtl/gds_seq_div.sv
module gds_seq_div #(
    parameter int NUM_W = 53,
    parameter int DEN_W = 41
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] nsh;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] den;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DEN_W:0] trial;
    logic           qbit;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        trial     = '0;
        qbit      = 1'b0;
        if (start && !st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
            st_d.rem = '0;
            st_d.nsh = num;
            st_d.quo = '0;
            st_d.den = den;
        end else if (st_q.run) begin
            trial = {st_q.rem, st_q.nsh[NUM_W-1]};
            if (trial >= {1'b0, st_q.den}) begin
                trial = trial - {1'b0, st_q.den};
                qbit  = 1'b1;
            end
            st_d.rem = trial[DEN_W-1:0];
            st_d.quo = {st_q.quo[NUM_W-2:0], qbit};
            st_d.nsh = st_q.nsh << 1;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(NUM_W - 1)) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign quo  = st_q.quo;

    // R1: partial remainder stays below a nonzero divisor
    p_rem_below_den_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.den != '0) |-> (st_q.rem < st_q.den));

    // R6: completion is a single-cycle event
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

endmodule

// File: rtl/gds_atan_cordic.sv
module gds_atan_cordic
    import gds_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ANG_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [IN_W-1:0]  tan_in,
    output logic                    done,
    output logic signed [ANG_W-1:0] angle
);
    localparam int XY_W = IN_W + XY_FRAC + 3;
    localparam int Z_W  = ANG_W + Z_FRAC;
    localparam int IW   = $clog2(CORDIC_ITER);

    typedef struct packed {
        logic            run;
        logic            done;
        logic [IW-1:0]   idx;
        logic [XY_W-1:0] x;
        logic [XY_W-1:0] y;
        logic [Z_W-1:0]  z;
    } cor_st_t;

    cor_st_t st_d, st_q;
    logic signed [XY_W-1:0] x_sh, y_sh;
    logic        [Z_W-1:0]  step;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        x_sh      = $signed(st_q.x) >>> st_q.idx;
        y_sh      = $signed(st_q.y) >>> st_q.idx;
        step      = Z_W'(atan_step_q8(int'(st_q.idx)));
        if (start && !st_q.run) begin
            st_d.run = 1'b1;
            st_d.idx = '0;
            st_d.x   = XY_W'(1000) << XY_FRAC;
            st_d.y   = XY_W'(tan_in) << XY_FRAC;
            st_d.z   = '0;
        end else if (st_q.run) begin
            if (!st_q.y[XY_W-1]) begin
                st_d.x = st_q.x + y_sh;
                st_d.y = st_q.y - x_sh;
                st_d.z = st_q.z + step;
            end else begin
                st_d.x = st_q.x - y_sh;
                st_d.y = st_q.y + x_sh;
                st_d.z = st_q.z - step;
            end
            st_d.idx = st_q.idx + 1'b1;
            if (st_q.idx == IW'(CORDIC_ITER - 1)) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done  = st_q.done;
    assign angle = ANG_W'(($signed(st_q.z) + Z_W'(1 << (Z_FRAC - 1))) >>> Z_FRAC);

    // R3: the vector never leaves the right half plane while rotating
    p_x_positive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> ($signed(st_q.x) > 0));

endmodule

// File: rtl/gds_angle_unit.sv
module gds_angle_unit
    import gds_pkg::*;
#(
    parameter int FREQ_W = 24,
    parameter int TAN_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [FREQ_W-1:0]       fa_khz,
    input  logic [FREQ_W-1:0]       fb_khz,
    input  logic [FREQ_W-1:0]       fc_khz,
    output logic                    busy,
    output logic                    out_valid,
    output logic signed [TAN_W-1:0] tan_milli,
    output logic signed [TAN_W-1:0] angle_mrad,
    output logic                    err
);
    localparam int DIFF_W = FREQ_W + 1;
    localparam int LIN_W  = FREQ_W + 3;
    localparam int NUM_W  = LIN_W + K_W;
    localparam int DEN_W  = DIFF_W + RATIO_FRAC;
    localparam logic signed [NUM_W-1:0] K_EXT   = NUM_W'(INV_SQRT3_Q);
    localparam logic [TAN_W-1:0]        TAN_MAX = {1'b0, {(TAN_W-1){1'b1}}};

    typedef struct packed {
        logic             busy;
        logic             err;
        logic             neg;
        logic [TAN_W-1:0] tan;
        logic             ov;
        logic [TAN_W-1:0] tan_o;
        logic [TAN_W-1:0] ang_o;
        logic             err_o;
    } top_st_t;

    top_st_t st_d, st_q;

    logic signed [DIFF_W-1:0] d_b, d_c;
    logic signed [LIN_W-1:0]  lin;
    logic signed [NUM_W-1:0]  prod;
    logic [NUM_W-1:0]         div_num;
    logic [DEN_W-1:0]         div_den;
    logic                     div_start, div_done;
    logic [NUM_W-1:0]         div_quo;
    logic [TAN_W-1:0]         tan_mag, tan_fin;
    logic                     cor_done;
    logic signed [TAN_W-1:0]  cor_angle;

    // operand formation
    always_comb begin
        d_b     = $signed({1'b0, fb_khz}) - $signed({1'b0, fa_khz});
        d_c     = $signed({1'b0, fc_khz}) - $signed({1'b0, fa_khz});
        lin     = LIN_W'(d_b) * 2 - LIN_W'(d_c);
        prod    = NUM_W'(lin) * K_EXT;
        div_num = prod[NUM_W-1] ? NUM_W'(-prod) : NUM_W'(prod);
        div_den = DEN_W'(d_c[DIFF_W-1] ? -d_c : d_c) << RATIO_FRAC;
    end

    assign div_start = in_valid && !st_q.busy;

    gds_seq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(div_start),
        .num  (div_num),
        .den  (div_den),
        .done (div_done),
        .quo  (div_quo)
    );

    // sign, clamp and degenerate-cell handling of the quotient
    always_comb begin
        tan_mag = (div_quo > NUM_W'(TAN_MAX)) ? TAN_MAX : TAN_W'(div_quo);
        if (st_q.err)      tan_fin = '0;
        else if (st_q.neg) tan_fin = -tan_mag;
        else               tan_fin = tan_mag;
    end

    gds_atan_cordic #(.IN_W(TAN_W), .ANG_W(TAN_W)) u_atan (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_done),
        .tan_in(tan_fin),
        .done  (cor_done),
        .angle (cor_angle)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        if (div_start) begin
            st_d.busy = 1'b1;
            st_d.err  = (d_c == '0);
            st_d.neg  = lin[LIN_W-1] ^ d_c[DIFF_W-1];
        end
        if (div_done) st_d.tan = tan_fin;
        if (cor_done) begin
            st_d.busy  = 1'b0;
            st_d.ov    = 1'b1;
            st_d.tan_o = st_q.tan;
            st_d.ang_o = st_q.err ? '0 : cor_angle;
            st_d.err_o = st_q.err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = st_q.busy;
    assign out_valid  = st_q.ov;
    assign tan_milli  = st_q.tan_o;
    assign angle_mrad = st_q.ang_o;
    assign err        = st_q.err_o;

    p_busy_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> busy);

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !busy);

    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(tan_milli) && $stable(angle_mrad) && $stable(err)));

    p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err) |-> (tan_milli == '0 && angle_mrad == '0));

    p_clamp_sym_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (tan_milli != {1'b1, {(TAN_W-1){1'b0}}}));

    p_neg_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && tan_milli < 0) |-> (angle_mrad < 0));

    p_pos_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && tan_milli > 0) |-> (angle_mrad > 0));

endmodule

// File: tb/gds_angle_unit_bench.sv
module gds_angle_unit_bench;
    localparam int FREQ_W = 24;
    localparam int TAN_W  = 16;
    localparam int LAT    = FREQ_W + 47;
    localparam int TMAX   = (1 << (TAN_W - 1)) - 1;

    typedef struct {
        int    tan;
        int    ang;
        bit    err;
        int    t_acc;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [FREQ_W-1:0] fa = '0, fb = '0, fc = '0;
    logic busy, out_valid, err;
    logic signed [TAN_W-1:0] tan_milli, angle_mrad;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gds_angle_unit #(.FREQ_W(FREQ_W), .TAN_W(TAN_W)) u_gds_angle_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .fa_khz(fa), .fb_khz(fb), .fc_khz(fc),
        .busy(busy), .out_valid(out_valid),
        .tan_milli(tan_milli), .angle_mrad(angle_mrad), .err(err));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int rnd(input real r);
        return (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
    endfunction

    task automatic send(input int a, input int b, input int c, input string req);
        exp_t e;
        real  db, dc, t;
        db = real'(b) - real'(a);
        dc = real'(c) - real'(a);
        if (c == a) begin
            e.tan = 0; e.err = 1'b1; e.ang = 0;
        end else begin
            t = 1000.0 * (2.0 * db - dc) / ($sqrt(3.0) * dc);
            if (t >= real'(TMAX))       e.tan = TMAX;
            else if (t <= -real'(TMAX)) e.tan = -TMAX;
            else                        e.tan = $rtoi(t);
            e.err = 1'b0;
            e.ang = rnd(1000.0 * $atan(real'(e.tan) / 1000.0));
        end
        e.req = req;
        @(negedge clk);
        while (busy) @(negedge clk);
        fa = FREQ_W'(a); fb = FREQ_W'(b); fc = FREQ_W'(c);
        in_valid = 1'b1;
        e.t_acc = cyc + 1;
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: compare each result against the oldest expected item
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7", "unexpected result", 1, 0);
            end else begin
                exp_t e;
                int   a;
                e = sb.pop_front();
                a = int'(angle_mrad);
                chk(int'(tan_milli) == e.tan, e.req, "tangent", int'(tan_milli), e.tan);
                chk(err == e.err, "R4", "error flag", int'(err), int'(e.err));
                chk((a - e.ang <= 1) && (e.ang - a <= 1), "R3", "angle", a, e.ang);
                chk(cyc - e.t_acc == LAT, "R6", "latency", cyc - e.t_acc, LAT);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(!busy && !out_valid && !err, "R9", "flags after reset",
            int'({busy, out_valid, err}), 0);
        chk(tan_milli == 0 && angle_mrad == 0, "R9", "data after reset",
            int'(tan_milli) + int'(angle_mrad), 0);

        send(10500, 10600, 10700, "R2");
        send(101000, 108000, 112000, "R2");
        send(120000, 130000, 137000, "R2");
        send(3000000, 3400000, 3700000, "R1");
        send(2000, 1400, 1000, "R1");          // both differences negative
        send(1000, 2000, 2000, "R1");          // near the 60 degree edge
        send(1000, 1100, 2000, "R8");          // negative tangent
        send(5000, 6000, 5000, "R4");          // degenerate cell
        send(100000, 200000, 100001, "R5");    // positive clamp
        send(100000, 0, 100001, "R5");         // negative clamp

        // R7: strobes while busy are ignored
        send(101000, 108000, 112000, "R7");
        repeat (5) @(negedge clk);
        chk(busy, "R7", "busy during request", int'(busy), 1);
        fa = 24'd10; fb = 24'd900000; fc = 24'd20;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        chk(busy, "R7", "busy after ignored strobe", int'(busy), 1);

        // R10: back-to-back requests after the pending one
        send(120000, 130000, 137000, "R10");
        send(10000, 10460, 10700, "R10");

        while (busy || sb.size() != 0) @(negedge clk);
        repeat (LAT + 20) @(negedge clk);
        chk(sb.size() == 0 && !busy, "R7", "idle at end", sb.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R6 watchdog expired actual=%0d expected=%0d", sb.size(), 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule